// File: doc/BRIEF.md
# CCD Line Pixel Region Classifier

This block follows the readout of one interline CCD frame, one digitized sample at a time. It keeps the current line and pixel position and gives every sample a region tag: serial-register dummy, shielded dark column, partly lit dark row, light-sensitive buffer, active image, or overclock. A downstream black-level clamp uses the active-window strobe and a per-line dark reference. The reference is taken only from the inner shielded columns of the leading dark margin, and only on lines that carry image or buffer rows.

Two small state machines cut the line and the frame into segments. The horizontal sequencer steps through the states `H_LDUMMY`, `H_LDARK`, `H_LBUF`, `H_ACT`, `H_RBUF`, `H_RDARK`, `H_RDUMMY` and `H_OVER`. The move to the next state takes place on the last sample of a segment. When the row is split between outputs, `H_ACT` goes directly to `H_OVER`. A line start forces `H_LDUMMY`. The vertical sequencer steps through `V_TDARK`, `V_TBUF`, `V_ACT`, `V_BBUF`, `V_BDARK`, `V_BDUMMY` and `V_OVER`, moving once per line start. In four-output mode `V_ACT` goes directly to `V_OVER`. A frame start forces `V_TDARK`. The dark accumulator is a third machine. In `ACC_WAIT` no eligible sample has arrived yet. `ACC_RUN` is entered on an eligible sample and `ACC_HAVE` on the last contributing sample. A line start returns it to `ACC_WAIT`, or to `ACC_RUN` when that start carries an eligible sample. A line start that arrives while the accumulator is in `ACC_RUN` raises the error flag.

Top module: `ccd_line_classifier`

## Requirements
- R1: After reset, `out_vld`, `act_vld`, `dark_done` and `dark_err` are 0 and `dark_avg` is 0. Every sample before the first frame start is tagged overclock.
- R2: Each sample with `pix_vld` high appears one cycle later with `out_vld` high, the same data on `out_data`, and a tag on `out_tag`. The tag codes are 0 dummy, 1 dark column, 2 dark row, 3 buffer, 4 active and 5 overclock.
- R3: Columns 0 to LEAD_DUM-1 of every line in the frame (11 by default) are tagged 0 (dummy). This includes the first sample of a frame.
- R4: After the dummies, the line carries DARK_COLS columns tagged 1 and then BUF_COLS columns tagged 3. In single-output mode, the active pixels are followed by a mirror of the leading segments: BUF_COLS buffer, DARK_COLS dark and LEAD_DUM dummy columns.
- R5: A line has ACT_W active columns in single-output mode and ACT_W/2 in two- or four-output mode. In the split modes every later column is overclock (5). In single-output mode, columns after the trailing dummies are overclock.
- R6: Line 0 after a frame start (the dummy row merged with the first dark row) up to line DARK_ROWS-1 is tagged dark row (2). Next come BUF_ROWS buffer rows, then ACT_H active rows (ACT_H/2 in four-output mode). Without four-output mode, these are followed by BUF_ROWS buffer rows, DARK_ROWS dark rows, one dummy line and then overclock lines. In four-output mode, overclock lines follow the active rows directly. Tag priority: row overclock, column dummy, column overclock, row dark, row dummy, column dark, buffer, active.
- R7: `act_vld` is high exactly when `out_vld` is high with tag 4.
- R8: On buffer and active rows, the leading dark columns at segment positions DARK_SKIP to DARK_COLS-DARK_SKIP-1 (the inner 20 by default) are summed. One cycle after the last of them, `dark_done` pulses and `dark_avg` holds floor(sum/20).
- R9: Dark-row, dummy-row and overclock lines never contribute. They produce no `dark_done` and no error, and `dark_avg` keeps its value.
- R10: A line start that ends an eligible line with at least one sample but fewer than the full set of contributing samples pulses `dark_err` one cycle later. `dark_avg` is unchanged.
- R11: `mode_sel` is taken only on a frame start (00 single, 01 dual, 10 quad, 11 single). Changes in the middle of a frame have no effect.
- R12: A frame start resets the line to 0 and wins over a coincident line start. A line start advances the line by one and resets the column, whether or not a sample comes with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_vld | input | 1 | Sample present this cycle |
| line_sol | input | 1 | Start of line; a sample in this cycle is column 0 |
| frame_sof | input | 1 | Start of frame; implies start of line 0 |
| mode_sel | input | 2 | Output split mode, taken at frame start |
| pix_data | input | DATA_W | Digitized sample |
| out_vld | output | 1 | Tagged sample valid |
| out_tag | output | 3 | Region code of the sample |
| out_data | output | DATA_W | Sample data, delayed one cycle |
| act_vld | output | 1 | Sample lies in the active window |
| dark_avg | output | DATA_W | Latest per-line dark reference |
| dark_done | output | 1 | Dark reference updated this cycle |
| dark_err | output | 1 | Line ended before the dark set completed |

## Verification
Completion of the dark reference and the short-line error both depend on where a line start falls, so they are tested against each other. A line that ends exactly on the 20th contributing sample must give `dark_done` and then no `dark_err` at the next line start. A line that ends one to several samples sooner must give `dark_err` one cycle after that start, with no done pulse and `dark_avg` holding the value of the previous line. The behavioural reference in the bench predicts both strobes and the held value on every cycle. Lone line starts, mid-frame mode changes and dark-row lines cut short are mixed into the same runs.

// File: rtl/ccd_region_pkg.sv
package ccd_region_pkg;

    typedef enum logic [2:0] {
        TAG_DUMMY   = 3'd0,
        TAG_DARKCOL = 3'd1,
        TAG_DARKROW = 3'd2,
        TAG_BUFFER  = 3'd3,
        TAG_ACTIVE  = 3'd4,
        TAG_OVERCLK = 3'd5
    } pix_tag_e;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_DUAL   = 2'd1,
        MODE_QUAD   = 2'd2,
        MODE_RSVD   = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        H_LDUMMY, H_LDARK, H_LBUF, H_ACT, H_RBUF, H_RDARK, H_RDUMMY, H_OVER
    } hreg_e;

    typedef enum logic [2:0] {
        V_TDARK, V_TBUF, V_ACT, V_BBUF, V_BDARK, V_BDUMMY, V_OVER
    } vreg_e;

    typedef enum logic [1:0] {
        ACC_WAIT, ACC_RUN, ACC_HAVE
    } acc_e;

endpackage

// File: rtl/ccd_hseq.sv
module ccd_hseq
    import ccd_region_pkg::*;
#(
    parameter int LEAD_DUM  = 11,
    parameter int DARK_COLS = 22,
    parameter int BUF_COLS  = 12,
    parameter int ACT_W     = 6576,
    parameter int IDX_W     = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp,
    input  logic             start,
    input  rd_mode_e         mode,
    output hreg_e            cur_st,
    output logic [IDX_W-1:0] cur_idx
);

    hreg_e            st_q, nxt_st;
    logic [IDX_W-1:0] idx_q, nxt_idx;
    logic             split;

    assign split = (mode == MODE_DUAL) || (mode == MODE_QUAD);

    function automatic logic [IDX_W-1:0] seg_len(hreg_e s, logic sp);
        logic [IDX_W-1:0] n;
        unique case (s)
            H_LDUMMY, H_RDUMMY: n = IDX_W'(LEAD_DUM);
            H_LDARK,  H_RDARK:  n = IDX_W'(DARK_COLS);
            H_LBUF,   H_RBUF:   n = IDX_W'(BUF_COLS);
            H_ACT:              n = sp ? IDX_W'(ACT_W / 2) : IDX_W'(ACT_W);
            default:            n = IDX_W'(1);
        endcase
        return n;
    endfunction

    function automatic hreg_e seg_next(hreg_e s, logic sp);
        hreg_e n;
        unique case (s)
            H_LDUMMY: n = H_LDARK;
            H_LDARK:  n = H_LBUF;
            H_LBUF:   n = H_ACT;
            H_ACT:    n = sp ? H_OVER : H_RBUF;
            H_RBUF:   n = H_RDARK;
            H_RDARK:  n = H_RDUMMY;
            H_RDUMMY: n = H_OVER;
            default:  n = H_OVER;
        endcase
        return n;
    endfunction

    // position of the sample in this cycle
    always_comb begin
        cur_st  = start ? H_LDUMMY : st_q;
        cur_idx = start ? '0 : idx_q;
    end

    always_comb begin
        nxt_st  = cur_st;
        nxt_idx = cur_idx;
        if (smp && cur_st != H_OVER) begin
            if (cur_idx == seg_len(cur_st, split) - IDX_W'(1)) begin
                nxt_st  = seg_next(cur_st, split);
                nxt_idx = '0;
            end else begin
                nxt_idx = cur_idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= H_OVER;
            idx_q <= '0;
        end else begin
            st_q  <= nxt_st;
            idx_q <= nxt_idx;
        end
    end

    // R5: once past the line, only a line start leaves overclock
    assert_hover_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == H_OVER && !start) |=> (st_q == H_OVER))
        else $error("horizontal overclock left without line start");

endmodule

// File: rtl/ccd_vseq.sv
module ccd_vseq
    import ccd_region_pkg::*;
#(
    parameter int DARK_ROWS = 22,
    parameter int BUF_ROWS  = 12,
    parameter int ACT_H     = 4384,
    parameter int IDX_W     = 13
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_start,
    input  logic     frame_start,
    input  rd_mode_e mode,
    output vreg_e    cur_st
);

    vreg_e            st_q, adv_st;
    logic [IDX_W-1:0] idx_q, adv_idx, cur_idx;
    logic             quad;

    assign quad = (mode == MODE_QUAD);

    function automatic logic [IDX_W-1:0] band_len(vreg_e s, logic q);
        logic [IDX_W-1:0] n;
        unique case (s)
            V_TDARK, V_BDARK: n = IDX_W'(DARK_ROWS);
            V_TBUF,  V_BBUF:  n = IDX_W'(BUF_ROWS);
            V_ACT:            n = q ? IDX_W'(ACT_H / 2) : IDX_W'(ACT_H);
            default:          n = IDX_W'(1);
        endcase
        return n;
    endfunction

    function automatic vreg_e band_next(vreg_e s, logic q);
        vreg_e n;
        unique case (s)
            V_TDARK:  n = V_TBUF;
            V_TBUF:   n = V_ACT;
            V_ACT:    n = q ? V_OVER : V_BBUF;
            V_BBUF:   n = V_BDARK;
            V_BDARK:  n = V_BDUMMY;
            default:  n = V_OVER;
        endcase
        return n;
    endfunction

    always_comb begin
        adv_st  = st_q;
        adv_idx = idx_q;
        if (st_q != V_OVER) begin
            if (idx_q == band_len(st_q, quad) - IDX_W'(1)) begin
                adv_st  = band_next(st_q, quad);
                adv_idx = '0;
            end else begin
                adv_idx = idx_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        if (frame_start) begin
            cur_st  = V_TDARK;
            cur_idx = '0;
        end else if (line_start) begin
            cur_st  = adv_st;
            cur_idx = adv_idx;
        end else begin
            cur_st  = st_q;
            cur_idx = idx_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= V_OVER;
            idx_q <= '0;
        end else begin
            st_q  <= cur_st;
            idx_q <= cur_idx;
        end
    end

    // R12: a frame start always lands on the first dark row
    assert_frame_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st_q == V_TDARK && idx_q == '0))
        else $error("frame start did not restart line count");

endmodule

// File: rtl/ccd_dark_avg.sv
module ccd_dark_avg
    import ccd_region_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int SKIP   = 1,
    parameter int USE    = 20,
    parameter int IDX_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp,
    input  logic              start,
    input  logic              in_dark,
    input  logic              row_ok,
    input  logic [IDX_W-1:0]  col_idx,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] avg_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int CNT_W = $clog2(USE + 1);
    localparam int SUM_W = DATA_W + $clog2(USE + 1);
    localparam int SHIFT = DATA_W + 3 * $clog2(USE + 1);
    localparam int RW    = SHIFT + 1;
    localparam int PW    = SUM_W + RW;
    localparam logic [RW-1:0] RECIP = ({1'b1, {SHIFT{1'b0}}} + RW'(USE - 1)) / RW'(USE);

    acc_e             st_q, nxt_st;
    logic [SUM_W-1:0] acc_q, sum_new;
    logic [CNT_W-1:0] cnt_q;
    logic             contrib, last, elig;

    assign elig    = smp && row_ok;
    assign contrib = elig && in_dark &&
                     (col_idx >= IDX_W'(SKIP)) && (col_idx < IDX_W'(SKIP + USE));
    assign last    = contrib && (cnt_q == CNT_W'(USE - 1));
    assign sum_new = acc_q + SUM_W'(data);

    always_comb begin
        nxt_st = st_q;
        if (start) begin
            nxt_st = elig ? ACC_RUN : ACC_WAIT;
        end else begin
            unique case (st_q)
                ACC_WAIT: if (elig) nxt_st = ACC_RUN;
                ACC_RUN:  if (last) nxt_st = ACC_HAVE;
                ACC_HAVE: nxt_st = ACC_HAVE;
                default:  nxt_st = ACC_WAIT;
            endcase
            if (last) nxt_st = ACC_HAVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACC_WAIT;
        else        st_q <= nxt_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            avg_o  <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            err_o  <= start && (st_q == ACC_RUN);
            done_o <= last;
            if (start) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (contrib) begin
                acc_q <= sum_new;
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (last)
                avg_o <= DATA_W'((PW'(sum_new) * PW'(RECIP)) >> SHIFT);
        end
    end

    // R10: a short line and a completed set never report together
    assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o))
        else $error("done and error in one cycle");

    // R8: one reference per line, never two cycles in a row
    assert_done_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("back-to-back dark done");

    // R9: the reference only moves with a done pulse
    assert_avg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(avg_o))
        else $error("dark reference changed without done");

endmodule

// File: rtl/ccd_line_classifier.sv
module ccd_line_classifier
    import ccd_region_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int LEAD_DUM  = 11,
    parameter int DARK_COLS = 22,
    parameter int DARK_SKIP = 1,
    parameter int BUF_COLS  = 12,
    parameter int ACT_W     = 6576,
    parameter int DARK_ROWS = 22,
    parameter int BUF_ROWS  = 12,
    parameter int ACT_H     = 4384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_vld,
    input  logic              line_sol,
    input  logic              frame_sof,
    input  logic [1:0]        mode_sel,
    input  logic [DATA_W-1:0] pix_data,
    output logic              out_vld,
    output logic [2:0]        out_tag,
    output logic [DATA_W-1:0] out_data,
    output logic              act_vld,
    output logic [DATA_W-1:0] dark_avg,
    output logic              dark_done,
    output logic              dark_err
);

    localparam int HIDX_W   = $clog2(ACT_W + DARK_COLS + BUF_COLS + LEAD_DUM + 1);
    localparam int VIDX_W   = $clog2(ACT_H + DARK_ROWS + BUF_ROWS + 2);
    localparam int USE_COLS = DARK_COLS - 2 * DARK_SKIP;

    rd_mode_e          mode_q, cur_mode;
    logic              start;
    hreg_e             h_st;
    logic [HIDX_W-1:0] h_idx;
    vreg_e             v_st;
    logic              row_ok, act_c;
    pix_tag_e          tag_c;

    assign start    = line_sol | frame_sof;
    assign cur_mode = frame_sof ? rd_mode_e'(mode_sel) : mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mode_q <= MODE_SINGLE;
        else if (frame_sof) mode_q <= rd_mode_e'(mode_sel);
    end

    ccd_hseq #(
        .LEAD_DUM (LEAD_DUM),
        .DARK_COLS(DARK_COLS),
        .BUF_COLS (BUF_COLS),
        .ACT_W    (ACT_W),
        .IDX_W    (HIDX_W)
    ) u_hseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp    (pix_vld),
        .start  (start),
        .mode   (cur_mode),
        .cur_st (h_st),
        .cur_idx(h_idx)
    );

    ccd_vseq #(
        .DARK_ROWS(DARK_ROWS),
        .BUF_ROWS (BUF_ROWS),
        .ACT_H    (ACT_H),
        .IDX_W    (VIDX_W)
    ) u_vseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_sol),
        .frame_start(frame_sof),
        .mode       (cur_mode),
        .cur_st     (v_st)
    );

    assign row_ok = (v_st == V_TBUF) || (v_st == V_ACT) || (v_st == V_BBUF);

    ccd_dark_avg #(
        .DATA_W(DATA_W),
        .SKIP  (DARK_SKIP),
        .USE   (USE_COLS),
        .IDX_W (HIDX_W)
    ) u_dark (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp    (pix_vld),
        .start  (start),
        .in_dark(h_st == H_LDARK),
        .row_ok (row_ok),
        .col_idx(h_idx),
        .data   (pix_data),
        .avg_o  (dark_avg),
        .done_o (dark_done),
        .err_o  (dark_err)
    );

    // region merge, highest priority first
    always_comb begin
        if (v_st == V_OVER)
            tag_c = TAG_OVERCLK;
        else if (h_st == H_LDUMMY || h_st == H_RDUMMY)
            tag_c = TAG_DUMMY;
        else if (h_st == H_OVER)
            tag_c = TAG_OVERCLK;
        else if (v_st == V_TDARK || v_st == V_BDARK)
            tag_c = TAG_DARKROW;
        else if (v_st == V_BDUMMY)
            tag_c = TAG_DUMMY;
        else if (h_st == H_LDARK || h_st == H_RDARK)
            tag_c = TAG_DARKCOL;
        else if (h_st == H_LBUF || h_st == H_RBUF || v_st == V_TBUF || v_st == V_BBUF)
            tag_c = TAG_BUFFER;
        else
            tag_c = TAG_ACTIVE;
    end

    assign act_c = (h_st == H_ACT) && (v_st == V_ACT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_tag  <= 3'd0;
            out_data <= '0;
            act_vld  <= 1'b0;
        end else begin
            out_vld <= pix_vld;
            act_vld <= pix_vld && act_c;
            if (pix_vld) begin
                out_tag  <= tag_c;
                out_data <= pix_data;
            end
        end
    end

    // R3: the first sample of a frame is a serial-register dummy
    assert_sof_dummy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && frame_sof) |=> (out_vld && out_tag == TAG_DUMMY))
        else $error("frame start sample not tagged dummy");

    // R7: active strobe only with a valid active-tagged sample
    assert_act_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
        act_vld |-> (out_vld && out_tag == TAG_ACTIVE))
        else $error("active strobe outside active tag");

    // R11: mode only moves on a frame start
    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sof |=> $stable(mode_q))
        else $error("mode changed mid-frame");

endmodule

// File: tb/ccd_line_classifier_tb.sv
module ccd_line_classifier_tb;

    localparam int DW   = 12;
    localparam int LD   = 11;
    localparam int DC   = 22;
    localparam int BC   = 12;
    localparam int AW   = 16;
    localparam int DR   = 3;
    localparam int BR   = 2;
    localparam int AH   = 8;
    localparam int FULL = 110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_vld = 1'b0, line_sol = 1'b0, frame_sof = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic [DW-1:0] pix_data = '0;
    logic          out_vld, act_vld, dark_done, dark_err;
    logic [2:0]    out_tag;
    logic [DW-1:0] out_data, dark_avg;

    always #5 clk = ~clk;

    ccd_line_classifier #(
        .DATA_W(DW), .LEAD_DUM(LD), .DARK_COLS(DC), .DARK_SKIP(1), .BUF_COLS(BC),
        .ACT_W(AW), .DARK_ROWS(DR), .BUF_ROWS(BR), .ACT_H(AH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .line_sol(line_sol),
        .frame_sof(frame_sof), .mode_sel(mode_sel), .pix_data(pix_data),
        .out_vld(out_vld), .out_tag(out_tag), .out_data(out_data), .act_vld(act_vld),
        .dark_avg(dark_avg), .dark_done(dark_done), .dark_err(dark_err)
    );

    int    checks = 0;
    int    fails  = 0;
    string ctx    = "-";

    // reference model state
    int m_row = 0, m_col = 0, m_mode = 0, m_acc = 0, m_cnt = 0, m_avg = 0;
    bit m_frame = 0, m_seen = 0, m_got = 0;
    bit e_vld = 0, e_act = 0, e_done = 0, e_err = 0;
    int e_tag = 0, e_data = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s [%s] actual=%0d expected=%0d t=%0t", req, what, ctx, act, exp, $time);
        end
    endtask

    // column class: 0 dummy, 1 dark, 2 buffer, 3 active, 4 overclock
    function automatic int hclass(int c, int md);
        int wa;
        bit sp;
        sp = (md == 1) || (md == 2);
        wa = sp ? AW / 2 : AW;
        if (c < LD) return 0;
        if (c < LD + DC) return 1;
        if (c < LD + DC + BC) return 2;
        if (c < LD + DC + BC + wa) return 3;
        if (sp) return 4;
        if (c < LD + DC + 2 * BC + AW) return 2;
        if (c < LD + 2 * DC + 2 * BC + AW) return 1;
        if (c < 2 * LD + 2 * DC + 2 * BC + AW) return 0;
        return 4;
    endfunction

    // row class: 0 dark, 1 buffer, 2 active, 3 dummy, 4 overclock
    function automatic int vclass(int r, int md);
        int ha;
        ha = (md == 2) ? AH / 2 : AH;
        if (r < DR) return 0;
        if (r < DR + BR) return 1;
        if (r < DR + BR + ha) return 2;
        if (md == 2) return 4;
        if (r < DR + 2 * BR + ha) return 1;
        if (r < 2 * DR + 2 * BR + ha) return 0;
        if (r < 2 * DR + 2 * BR + ha + 1) return 3;
        return 4;
    endfunction

    function automatic string tag_req(int t);
        case (t)
            0: return "R3";
            1: return "R4";
            2: return "R6";
            3: return "R4";
            4: return "R5";
            default: return "R5";
        endcase
    endfunction

    task automatic model(input bit v, input bit sl, input bit sf, input int d, input int m);
        int hc, vc;
        e_done = 0;
        e_err  = 0;
        if (sl || sf) begin
            e_err  = m_seen && !m_got;
            m_acc  = 0;
            m_cnt  = 0;
            m_seen = 0;
            m_got  = 0;
            m_col  = 0;
            if (sf) begin
                m_frame = 1;
                m_mode  = (m == 3) ? 0 : m;
                m_row   = 0;
            end else begin
                m_row++;
            end
        end
        e_vld = v;
        e_act = 0;
        if (v) begin
            hc = hclass(m_col, m_mode);
            vc = vclass(m_row, m_mode);
            if (!m_frame || vc == 4) e_tag = 5;
            else if (hc == 0)        e_tag = 0;
            else if (hc == 4)        e_tag = 5;
            else if (vc == 0)        e_tag = 2;
            else if (vc == 3)        e_tag = 0;
            else if (hc == 1)        e_tag = 1;
            else if (hc == 2 || vc == 1) e_tag = 3;
            else                     e_tag = 4;
            e_act  = (e_tag == 4);
            e_data = d;
            if (m_frame && (vc == 1 || vc == 2)) begin
                m_seen = 1;
                if (m_col >= LD + 1 && m_col <= LD + DC - 2) begin
                    m_acc += d;
                    m_cnt++;
                    if (m_cnt == DC - 2) begin
                        e_done = 1;
                        m_avg  = m_acc / (DC - 2);
                        m_got  = 1;
                    end
                end
            end
            m_col++;
        end
    endtask

    task automatic compare();
        chk("R2", "out_vld", int'(out_vld), int'(e_vld));
        if (e_vld) begin
            chk(tag_req(e_tag), "out_tag", int'(out_tag), e_tag);
            chk("R2", "out_data", int'(out_data), e_data);
        end
        chk("R7", "act_vld", int'(act_vld), int'(e_act));
        chk("R8", "dark_done", int'(dark_done), int'(e_done));
        chk("R8", "dark_avg", int'(dark_avg), m_avg);
        chk("R10", "dark_err", int'(dark_err), int'(e_err));
    endtask

    task automatic step(input bit v, input bit sl, input bit sf, input int d, input int m);
        @(negedge clk);
        compare();
        pix_vld   = v;
        line_sol  = sl;
        frame_sof = sf;
        pix_data  = DW'(d);
        mode_sel  = 2'(m);
        model(v, sl, sf, d, m);
    endtask

    function automatic int pat(int seed, int c);
        if (seed < 0) return (1 << DW) - 1;
        return (seed * 131 + c * 29 + (c * c) % 17) % (1 << DW);
    endfunction

    task automatic run_line(input int n, input bit sof, input bit lone, input int m,
                            input int seed, input int gap);
        bit first;
        first = 1;
        if (lone) begin
            step(0, !sof, sof, 0, m);
            first = 0;
        end
        for (int c = 0; c < n; c++) begin
            step(1, first && !sof, first && sof, pat(seed, c), m);
            first = 0;
            if (gap > 0 && (c % gap) == gap - 1) step(0, 0, 0, 0, m);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired [%s]", ctx);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        ctx = "R1";
        chk("R1", "out_vld", int'(out_vld), 0);
        chk("R1", "act_vld", int'(act_vld), 0);
        chk("R1", "dark_done", int'(dark_done), 0);
        chk("R1", "dark_err", int'(dark_err), 0);
        chk("R1", "dark_avg", int'(dark_avg), 0);
        rst_n = 1'b1;

        // R1: samples before any frame start are overclock
        step(1, 0, 0, 7, 0);
        step(1, 1, 0, 9, 0);
        step(1, 0, 0, 11, 0);

        // frame A: single output, gaps, one lone line start (R12)
        for (int r = 0; r < 21; r++) begin
            ctx = (r == 7) ? "R12" : "single";
            run_line(FULL, r == 0, r == 7, 0, r, (r % 3 == 0) ? 0 : 9);
        end

        // frame B: dual output, mode input flips to quad mid-frame (R11)
        for (int r = 0; r < 21; r++) begin
            ctx = (r >= 5) ? "R11" : "dual";
            run_line(FULL, r == 0, 0, (r >= 5) ? 2 : 1, r + 40, 0);
        end

        // frame C: quad output, one saturated dark line
        for (int r = 0; r < 13; r++) begin
            ctx = (r == 6) ? "R8 max" : "quad";
            run_line(FULL, r == 0, 0, 2, (r == 6) ? -1 : r + 80, 5);
        end

        // frame D: short lines racing the dark set (R9, R10)
        ctx = "R9";
        run_line(20, 1, 0, 0, 3, 0);
        ctx = "single";
        run_line(FULL, 0, 0, 0, 4, 0);
        run_line(FULL, 0, 0, 0, 5, 0);
        ctx = "R10 short 15";
        run_line(27, 0, 0, 0, 6, 0);
        ctx = "R10 exact 20";
        run_line(32, 0, 0, 0, 7, 0);
        ctx = "R10 dummies only";
        run_line(10, 0, 0, 0, 8, 0);
        ctx = "R10 short 19";
        run_line(31, 0, 0, 0, 9, 0);
        ctx = "R10 lone start";
        run_line(FULL, 0, 1, 3, 10, 0);
        ctx = "single";
        run_line(FULL, 0, 0, 0, 11, 0);

        // frame E: lone frame start, reserved mode code (R12, R11)
        ctx = "R12 lone sof";
        run_line(FULL, 1, 1, 3, 12, 0);
        for (int r = 1; r < 8; r++) begin
            ctx = "R11 reserved";
            run_line(FULL, 0, 0, 3, r + 120, 7);
        end

        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule